// File: doc/BRIEF.md
# Compare-Channel Interval Timer

This block is a memory-mapped timer. An up counter advances once per prescaled tick. It wraps to zero after it reaches a programmable limit and marks each wrap in a sticky overflow flag. A single compare channel watches the counter. When the channel is in software-compare mode and the counter steps onto the programmed compare value, the channel sets a sticky event flag. An interrupt line follows that flag when the channel's interrupt enable is on.

Software controls the block through a 32-bit register port. Writes take effect on the next clock edge, and reads return data in the same cycle. The counter width is a parameter that may be 16 or 32 bits. A read-only register reports the width so that a driver can choose the prescaler and the limit. Both sticky flags are cleared by writing one to them. A typical one-shot use is to read the counter, add a delay, write the sum as the compare value, and wait for the interrupt.

Top module: `cmp_timer`

## Requirements
- R1: The identity register at offset 0x04 reads the counter width in bits 23:16 (0x20 for 32 bits, 0x10 for 16 bits) with all other bits zero. Unmapped offsets such as 0x08 read zero.
- R2: In the control register at 0x10, bits 2:0 hold a divider exponent d and bit 3 is the run bit. While run is 1, the counter at 0x14 advances once every 2^d clocks, and its first advance comes 2^d clocks after the write that set run. While run is 0, the counter holds its value.
- R3: On the tick where the counter equals the limit register at 0x18, the counter returns to zero and control bit 7 (the overflow flag) sets. Writing 1 to control bit 7 clears the flag.
- R4: Any write to the counter register sets the count to zero, whatever data it carries.
- R5: After reset, control reads 0, the counter reads 0, the limit reads all ones over the counter width, channel control (0x20) and compare value (0x24) read 0, and the interrupt output is low.
- R6: Channel control bits 5:2 hold the channel mode, bit 6 is the interrupt enable and bit 7 is the channel flag. With mode 4, the flag sets on the tick that brings the counter to the compare value. With any other mode the flag does not set.
- R7: Bit 0 of the status register at 0x1C reads the channel flag. Writing 1 to that bit, or writing 1 to channel-control bit 7, clears the flag.
- R8: The interrupt output is high exactly when the channel flag is set, the interrupt enable is 1 and the channel mode is nonzero.
- R9: A control or channel-control write with 0 in the flag bit leaves that flag unchanged, even when the write clears the mode. A set and a write-one-to-clear in the same cycle leave the flag set.
- R10: Control bits 6:4 and 31:8, and channel-control bits 1:0 and 31:8, read zero.
- R11: With a 16-bit counter, the counter, limit and compare registers read zero-extended to 32 bits, and write data above bit 15 is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Channel interrupt request |

## Verification
Random trials vary the divider exponent, the limit, the compare value, the run time and the channel mode. Comparing counter values across exponents shows that the prescaler divides correctly. Run times longer than the limit separate wrap-to-zero from free counting, and a compare value of zero shows that a match can come only from a wrap. Trials with a mode other than 4 show that the match logic depends on the mode. Directed cases place a clear on the same edge as a match, clear the mode while keeping the flag, and use a second instance with a 16-bit counter to show that reads are zero-extended.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
   localparam int unsigned OFS_IDENT  = 8'h04;
   localparam int unsigned OFS_CTRL   = 8'h10;
   localparam int unsigned OFS_COUNT  = 8'h14;
   localparam int unsigned OFS_LIMIT  = 8'h18;
   localparam int unsigned OFS_STAT   = 8'h1C;
   localparam int unsigned OFS_CHCTL  = 8'h20;
   localparam int unsigned OFS_CHVAL  = 8'h24;
   localparam int unsigned DIV_W      = 3;
   localparam int unsigned PRE_W      = 1 << DIV_W;
   localparam int unsigned MODE_W     = 4;
   localparam logic [MODE_W-1:0] MODE_SWCMP = 4'h4;
   localparam int unsigned RUN_BIT    = 3;
   localparam int unsigned FLAG_BIT   = 7;
   localparam int unsigned IE_BIT     = 6;
   localparam int unsigned MODE_LSB   = 2;
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale
   import cmp_timer_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   assign mask = (PRE_W'(1) << div) - PRE_W'(1);
   assign tick = run && ((pre_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (!run || clr)
         pre_q <= '0;
      else
         pre_q <= pre_q + PRE_W'(1);
   end

   // R2
   stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> pre_q == '0);
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             zero_wr,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             step,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   assign step    = tick && !zero_wr;
   assign cnt_nxt = (cnt_q == limit) ? '0 : cnt_q + CNT_W'(1);
   assign wrap    = step && (cnt_q == limit);
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (zero_wr)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_nxt;
   end

   // R4
   zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_wr |=> cnt_q == '0);
   // R2
   hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !zero_wr) |=> $stable(cnt_q));
   // R3
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt_q == '0);
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
   import cmp_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              stat_wr,
   input  logic              val_wr,
   input  logic [31:0]       wdata,
   input  logic              step,
   input  logic [CNT_W-1:0]  cnt_nxt,
   output logic              flag,
   output logic              ie,
   output logic [MODE_W-1:0] mode,
   output logic [CNT_W-1:0]  cmp_val
);
   logic match;
   logic clr;

   assign match = step && (mode == MODE_SWCMP) && (cnt_nxt == cmp_val);
   assign clr   = (ctl_wr && wdata[FLAG_BIT]) || (stat_wr && wdata[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         ie      <= 1'b0;
         mode    <= '0;
         cmp_val <= '0;
      end else begin
         if (match)
            flag <= 1'b1;
         else if (clr)
            flag <= 1'b0;
         if (ctl_wr) begin
            ie   <= wdata[IE_BIT];
            mode <= wdata[MODE_LSB +: MODE_W];
         end
         if (val_wr)
            cmp_val <= wdata[CNT_W-1:0];
      end
   end

   // R9
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && clr) |=> flag);
   // R6
   flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(step) && $past(mode) == MODE_SWCMP);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import cmp_timer_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   localparam logic [7:0] WIDTH_CODE = 8'(CNT_W);

   if (!(CNT_W == 16 || CNT_W == 32)) begin : g_bad_width
      $error("cmp_timer: CNT_W must be 16 or 32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("cmp_timer: ADDR_W too small for the register map");
   end

   logic [DIV_W-1:0]  div_q;
   logic              run_q;
   logic              ovf_q;
   logic [CNT_W-1:0]  limit_q;
   logic [CNT_W-1:0]  cnt, cnt_nxt, cmp_val;
   logic              tick, step, wrap;
   logic              ch_flag, ch_ie;
   logic [MODE_W-1:0] ch_mode;
   logic              wr_ctrl, wr_count, wr_limit, wr_stat, wr_chctl, wr_chval;
   logic [31:0]       cnt_rd, limit_rd, cmp_rd;

   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_count = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
   assign wr_limit = bus_wr && (bus_addr == ADDR_W'(OFS_LIMIT));
   assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
   assign wr_chctl = bus_wr && (bus_addr == ADDR_W'(OFS_CHCTL));
   assign wr_chval = bus_wr && (bus_addr == ADDR_W'(OFS_CHVAL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         run_q   <= 1'b0;
         ovf_q   <= 1'b0;
         limit_q <= '1;
      end else begin
         if (wr_ctrl) begin
            div_q <= bus_wdata[DIV_W-1:0];
            run_q <= bus_wdata[RUN_BIT];
         end
         if (wrap)
            ovf_q <= 1'b1;
         else if (wr_ctrl && bus_wdata[FLAG_BIT])
            ovf_q <= 1'b0;
         if (wr_limit)
            limit_q <= bus_wdata[CNT_W-1:0];
      end
   end

   cmp_timer_prescale i_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .clr   (wr_count),
      .div   (div_q),
      .tick  (tick)
   );

   cmp_timer_count #(.CNT_W(CNT_W)) i_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .tick    (tick),
      .zero_wr (wr_count),
      .limit   (limit_q),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt),
      .step    (step),
      .wrap    (wrap)
   );

   cmp_timer_chan #(.CNT_W(CNT_W)) i_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_wr  (wr_chctl),
      .stat_wr (wr_stat),
      .val_wr  (wr_chval),
      .wdata   (bus_wdata),
      .step    (step),
      .cnt_nxt (cnt_nxt),
      .flag    (ch_flag),
      .ie      (ch_ie),
      .mode    (ch_mode),
      .cmp_val (cmp_val)
   );

   if (CNT_W < 32) begin : g_zext
      assign cnt_rd   = {{(32-CNT_W){1'b0}}, cnt};
      assign limit_rd = {{(32-CNT_W){1'b0}}, limit_q};
      assign cmp_rd   = {{(32-CNT_W){1'b0}}, cmp_val};
   end else begin : g_full
      assign cnt_rd   = 32'(cnt);
      assign limit_rd = 32'(limit_q);
      assign cmp_rd   = 32'(cmp_val);
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_IDENT): bus_rdata = {8'h00, WIDTH_CODE, 16'h0000};
         ADDR_W'(OFS_CTRL):  bus_rdata = {24'h0, ovf_q, 3'b000, run_q, div_q};
         ADDR_W'(OFS_COUNT): bus_rdata = cnt_rd;
         ADDR_W'(OFS_LIMIT): bus_rdata = limit_rd;
         ADDR_W'(OFS_STAT):  bus_rdata = {31'h0, ch_flag};
         ADDR_W'(OFS_CHCTL): bus_rdata = {24'h0, ch_flag, ch_ie, ch_mode, 2'b00};
         ADDR_W'(OFS_CHVAL): bus_rdata = cmp_rd;
         default:            bus_rdata = '0;
      endcase
   end

   assign irq = ch_flag && ch_ie && (ch_mode != '0);

   // R3
   ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> $past(step) && $past(cnt) == $past(limit_q));
   // R8
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ch_ie);
endmodule

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        wr32 = 1'b0;
   logic        wr16 = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] rdata32, rdata16;
   logic        irq32, irq16;
   int          checks = 0;
   int          errors = 0;
   logic [31:0] rv;

   always #10 clk = ~clk;

   cmp_timer i_cmp_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(wr32),
      .bus_wdata(bus_wdata), .bus_rdata(rdata32), .irq(irq32));

   cmp_timer #(.CNT_W(16)) i_cmp_timer_w16 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(wr16),
      .bus_wdata(bus_wdata), .bus_rdata(rdata16), .irq(irq16));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit narrow = 0);
      bus_addr  = a;
      bus_wdata = d;
      if (narrow) wr16 = 1'b1; else wr32 = 1'b1;
      @(negedge clk);
      wr32 = 1'b0;
      wr16 = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d, input bit narrow = 0);
      bus_addr = a;
      #1;
      d = narrow ? rdata16 : rdata32;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [31:0] exp_cnt(int k, int d, int lim);
      int t = k >> d;
      return 32'(t % (lim + 1));
   endfunction

   function automatic logic exp_ovf(int k, int d, int lim);
      return (k >> d) > lim;
   endfunction

   function automatic logic exp_flag(int k, int d, int lim, int cv, int md);
      int t = k >> d;
      if (md != 4) return 1'b0;
      if (cv == 0) return t > lim;
      return t >= cv;
   endfunction

   task automatic prepare(input int lim, input int cv, input int md);
      wr(8'h10, 32'h0000_0080);
      wr(8'h14, 32'h0);
      wr(8'h18, 32'(lim));
      wr(8'h24, 32'(cv));
      wr(8'h20, 32'h80 | 32'h40 | 32'(md << 2));
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h1357);
      idle(2);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 reset state
      rd(8'h10, rv); check("R5 ctrl", rv, 32'h0);
      rd(8'h14, rv); check("R5 count", rv, 32'h0);
      rd(8'h18, rv); check("R5 limit", rv, 32'hFFFF_FFFF);
      rd(8'h20, rv); check("R5 chctl", rv, 32'h0);
      rd(8'h24, rv); check("R5 cmp", rv, 32'h0);
      check("R5 irq", {31'h0, irq32}, 32'h0);

      // R1 identity register
      rd(8'h04, rv); check("R1 ident32", rv, 32'h0020_0000);
      rd(8'h04, rv, 1); check("R1 ident16", rv, 32'h0010_0000);
      rd(8'h08, rv); check("R1 unmapped", rv, 32'h0);

      // R10 reserved bits
      wr(8'h10, 32'hFFFF_FF77);
      rd(8'h10, rv); check("R10 ctrl", rv, 32'h0000_0007);
      wr(8'h20, 32'hFFFF_FF7F);
      rd(8'h20, rv); check("R10 chctl", rv, 32'h0000_007C);
      wr(8'h20, 32'h0);

      // R11 16-bit zero extension
      rd(8'h18, rv, 1); check("R11 limit16 reset", rv, 32'h0000_FFFF);
      wr(8'h24, 32'hABCD_1234, 1);
      rd(8'h24, rv, 1); check("R11 cmp16", rv, 32'h0000_1234);
      wr(8'h18, 32'h5A5A_0009, 1);
      wr(8'h10, 32'h0000_0008, 1);
      idle(25);
      rd(8'h14, rv, 1); check("R11 count16 wrap", rv, 32'(25 % 10));

      // R2 R3 R6 R7 R8 random trials
      for (int t = 0; t < 10; t++) begin
         int d, lim, cv, md, k;
         d   = $urandom_range(0, 3);
         lim = $urandom_range(3, 20);
         cv  = $urandom_range(0, lim);
         md  = ($urandom_range(0, 3) == 0) ? 1 : 4;
         k   = $urandom_range(0, 150);
         if (t == 0) begin d = 0; lim = 5; cv = 0; md = 4; k = 6; end
         if (t == 1) begin d = 3; lim = 4; cv = 2; md = 4; k = 15; end
         prepare(lim, cv, md);
         wr(8'h10, 32'h8 | 32'(d));
         idle(k);
         rd(8'h14, rv); check("R2 count", rv, exp_cnt(k, d, lim));
         rd(8'h10, rv); check("R3 ovf", {31'h0, rv[7]}, {31'h0, exp_ovf(k, d, lim)});
         rd(8'h20, rv); check("R6 flag", {31'h0, rv[7]}, {31'h0, exp_flag(k, d, lim, cv, md)});
         rd(8'h1C, rv); check("R7 mirror", rv, {31'h0, exp_flag(k, d, lim, cv, md)});
         check("R8 irq", {31'h0, irq32}, {31'h0, exp_flag(k, d, lim, cv, md)});
      end

      // R3 overflow clear
      prepare(2, 1, 4);
      wr(8'h10, 32'h8);
      idle(7);
      rd(8'h10, rv); check("R3 ovf set", {31'h0, rv[7]}, 32'h1);
      wr(8'h10, 32'h80);
      rd(8'h10, rv); check("R3 ovf cleared", rv, 32'h0);

      // R2 stopped counter holds
      rd(8'h14, rv);
      begin
         logic [31:0] held;
         held = rv;
         idle(5);
         rd(8'h14, rv); check("R2 hold", rv, held);
      end

      // R9 set and clear on the same edge
      prepare(32'h7FFF_FFFF, 10, 4);
      wr(8'h10, 32'h8);
      idle(9);
      wr(8'h1C, 32'h1);
      rd(8'h1C, rv); check("R9 collision", rv, 32'h1);
      wr(8'h1C, 32'h1);
      rd(8'h1C, rv); check("R7 stat clear", rv, 32'h0);

      // R4 counter write
      idle(4);
      wr(8'h14, 32'h1234_5678);
      rd(8'h14, rv); check("R4 zero", rv, 32'h0);

      // R8 R9 gating and flag retention
      prepare(32'h7FFF_FFFF, 3, 4);
      wr(8'h10, 32'h8);
      idle(5);
      check("R8 irq on", {31'h0, irq32}, 32'h1);
      wr(8'h20, 32'h40);
      rd(8'h20, rv); check("R9 mode clear keeps flag", rv, 32'hC0);
      check("R8 irq mode0", {31'h0, irq32}, 32'h0);
      wr(8'h20, 32'h10);
      rd(8'h20, rv); check("R8 ie off", rv, 32'h90);
      check("R8 irq ie0", {31'h0, irq32}, 32'h0);
      wr(8'h20, 32'h90);
      rd(8'h20, rv); check("R7 chctl clear", rv, 32'h10);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 50000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule